// File: doc/BRIEF.md
# Multi-line receive silo controller

This block gathers characters from eight serial receivers into one shared receive buffer. The host drains that buffer one word per read. Each receiver line has its own small input queue and a receive-enable bit. The host sets that bit with a line-parameter write. A line whose enable is clear drops whatever arrives on it.

A host read pops one character. The character comes from the lowest-numbered line that has something queued. The read returns it as a 16-bit word tagged with the line number and its status bits. A master scan enable gates reading and the status flags. While it is off, reads return zero and pop nothing.

The block keeps three outputs for the host:
- A receive-done flag.
- A one-shot silo-alarm flag that fires when the total backlog reaches a threshold.
- A receive interrupt. A mode bit chooses whether the interrupt follows the alarm or the done flag.

Top module: `rx_silo_ctrl`

## Requirements
- R1: A read that finds data returns, one cycle later on `rd_data`, a word laid out as follows. Bits 7:0 hold the character. Bits 10:8 hold the source line. Bit 13 is the break (framing-error) flag. Bit 15 is the valid flag. Bits 14, 12 and 11 are zero.
- R2: A read pops the head of the lowest-numbered non-empty line queue. A read that finds nothing pending returns 16'h0000.
- R3: A character received with `rx_brk` set reads back with bits 15 and 13 set, the line number filled in, and a zero character field.
- R4: `rx_done` is high exactly while scan is enabled and at least one character is queued.
- R5: While the alarm is armed and scan is enabled, the total queued count reaching 16 sets `silo_alarm` on the next clock edge. Setting it disarms the alarm, so it does not fire again until re-armed.
- R6: Every read clears `silo_alarm`. A read that finds the queues empty re-arms the alarm, and so does `clr`.
- R7: `rx_irq` requires `rx_ie`. With `alarm_ie` set it follows `silo_alarm`; otherwise it follows `rx_done`.
- R8: While `scan_en` is low, reads return zero and pop nothing. In that state `rx_done` and `silo_alarm` are held low.
- R9: A `lpr_we` write takes the line number from `lpr_data[2:0]` and that line's receive enable from `lpr_data[12]`. Other bits are ignored. A disabled line queues nothing.
- R10: Each line queue holds 4 characters. A character that arrives while its queue is full is dropped.
- R11: Reset and `clr` empty all queues, clear every receive enable, zero `rd_data` and re-arm the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear pulse |
| scan_en | input | 1 | Master scan enable |
| rx_ie | input | 1 | Receive interrupt enable |
| alarm_ie | input | 1 | Interrupt source select: alarm when 1, done when 0 |
| lpr_we | input | 1 | Line-parameter write strobe |
| lpr_data | input | 16 | Line-parameter write data |
| rx_vld | input | 8 | Per-line character arrival strobe |
| rx_brk | input | 8 | Per-line break flag qualifying `rx_vld` |
| rx_char | input | 64 | Per-line character, line n in bits 8n+7:8n |
| rd_en | input | 1 | Host read of the receive buffer |
| rd_data | output | 16 | Receive word of the last read |
| rx_done | output | 1 | Receive-done flag |
| silo_alarm | output | 1 | Silo-alarm flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The properties assume that `rd_en`, `clr` and `lpr_we` are qualified by the clock only. They also assume that `clr` dominates any read or arrival in the same cycle. They take no position on arrivals colliding with reads. The stimulus avoids that collision and applies one event per cycle: a single line arrival, a single read, or a single parameter write, each held for one cycle and driven on the falling edge. The bench can therefore know the exact queue contents when it predicts each read word. The alarm sequence fills to just below the threshold, then to it, and then to it again while disarmed. It drains to an empty read before refilling, so both re-arm paths are exercised.

// File: rtl/rx_silo_ctrl.sv
module rx_silo_ctrl #(
  parameter int NLINES    = 8,
  parameter int QDEPTH    = 4,
  parameter int CW        = 8,
  parameter int ALARM_LVL = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 scan_en,
  input  logic                 rx_ie,
  input  logic                 alarm_ie,
  input  logic                 lpr_we,
  input  logic [15:0]          lpr_data,
  input  logic [NLINES-1:0]    rx_vld,
  input  logic [NLINES-1:0]    rx_brk,
  input  logic [NLINES*CW-1:0] rx_char,
  input  logic                 rd_en,
  output logic [15:0]          rd_data,
  output logic                 rx_done,
  output logic                 silo_alarm,
  output logic                 rx_irq
);
  localparam int LW       = $clog2(NLINES);
  localparam int PW       = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CNTW     = $clog2(QDEPTH + 1);
  localparam int TOTW     = $clog2(NLINES * QDEPTH + 1);
  localparam int EN_BIT   = 12;
  localparam int LINE_LSB = 8;
  localparam int BRK_BIT  = 13;
  localparam int VLD_BIT  = 15;

  logic [NLINES-1:0]      en, nonempty, pop_oh;
  logic [CW:0]            head [NLINES];
  logic [NLINES*CNTW-1:0] cnt_vec;
  logic [TOTW-1:0]        total;
  logic [LW-1:0]          sel;
  logic [15:0]            word;
  logic                   armed;

  wire any  = |nonempty;
  wire take = rd_en & scan_en & any;

  assign pop_oh = take ? (NLINES'(1) << sel) : '0;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [CW:0]     q [QDEPTH];
    logic [PW-1:0]   wp, rp;
    logic [CNTW-1:0] cnt;
    wire push = rx_vld[g] & en[g] & (cnt != CNTW'(QDEPTH));
    wire pop  = pop_oh[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp <= '0; rp <= '0; cnt <= '0;
      end else if (clr) begin
        wp <= '0; rp <= '0; cnt <= '0;
      end else begin
        if (push) wp <= (wp == PW'(QDEPTH - 1)) ? '0 : wp + 1'b1;
        if (pop)  rp <= (rp == PW'(QDEPTH - 1)) ? '0 : rp + 1'b1;
        cnt <= cnt + CNTW'(push) - CNTW'(pop);
      end
    end

    always_ff @(posedge clk)
      if (push) q[wp] <= {rx_brk[g], rx_char[g*CW +: CW]};

    assign head[g]                  = q[rp];
    assign nonempty[g]              = (cnt != '0);
    assign cnt_vec[g*CNTW +: CNTW]  = cnt;
  end

  always_comb begin
    sel = '0;
    for (int i = NLINES - 1; i >= 0; i--)
      if (nonempty[i]) sel = LW'(i);
  end

  always_comb begin
    total = '0;
    for (int i = 0; i < NLINES; i++)
      total = total + TOTW'(cnt_vec[i*CNTW +: CNTW]);
  end

  always_comb begin
    word                      = '0;
    word[VLD_BIT]             = 1'b1;
    word[BRK_BIT]             = head[sel][CW];
    word[LINE_LSB +: LW]      = sel;
    word[CW-1:0]              = head[sel][CW] ? '0 : head[sel][CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en <= '0;
    else if (clr)    en <= '0;
    else if (lpr_we) en[lpr_data[LW-1:0]] <= lpr_data[EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (clr)   rd_data <= '0;
    else if (rd_en) rd_data <= take ? word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      silo_alarm <= 1'b0; armed <= 1'b1;
    end else if (clr) begin
      silo_alarm <= 1'b0; armed <= 1'b1;
    end else if (!scan_en) begin
      silo_alarm <= 1'b0;
    end else if (rd_en) begin
      silo_alarm <= 1'b0;
      if (!any) armed <= 1'b1;
    end else if (armed && total >= TOTW'(ALARM_LVL)) begin
      silo_alarm <= 1'b1; armed <= 1'b0;
    end
  end

  assign rx_done = scan_en & any;
  assign rx_irq  = rx_ie & (alarm_ie ? silo_alarm : rx_done);
endmodule

// File: rtl/rx_silo_ctrl_chk.sv
module rx_silo_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clr,
  input logic        scan_en,
  input logic        rx_ie,
  input logic        alarm_ie,
  input logic        rd_en,
  input logic [15:0] rd_data,
  input logic        rx_done,
  input logic        silo_alarm,
  input logic        rx_irq
);
  p_read_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rx_done && !clr) |=> (rd_data[15] && !rd_data[14] && rd_data[12:11] == 2'b00));

  p_empty_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rx_done && !clr) |=> (rd_data == 16'h0000));

  p_done_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |-> !rx_done);

  p_alarm_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(silo_alarm) |-> $past(rx_done));

  p_alarm_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || clr) |=> !silo_alarm);

  p_irq_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_ie);

  p_irq_alarm_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ie && alarm_ie) |-> (rx_irq == silo_alarm));

  p_scan_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> !silo_alarm);

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!rx_done && rd_data == 16'h0000));
endmodule

bind rx_silo_ctrl rx_silo_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .scan_en(scan_en), .rx_ie(rx_ie),
  .alarm_ie(alarm_ie), .rd_en(rd_en), .rd_data(rd_data), .rx_done(rx_done),
  .silo_alarm(silo_alarm), .rx_irq(rx_irq)
);

// File: tb/rx_silo_ctrl_tb.sv
module rx_silo_ctrl_tb;
  localparam int NL = 8, CW = 8, QD = 4;

  logic clk = 0, rst_n = 0, clr = 0, scan_en = 0, rx_ie = 0, alarm_ie = 0;
  logic lpr_we = 0, rd_en = 0;
  logic [15:0] lpr_data = '0;
  logic [NL-1:0] rx_vld = '0, rx_brk = '0;
  logic [NL*CW-1:0] rx_char = '0;
  wire [15:0] rd_data;
  wire rx_done, silo_alarm, rx_irq;

  rx_silo_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .scan_en(scan_en), .rx_ie(rx_ie),
    .alarm_ie(alarm_ie), .lpr_we(lpr_we), .lpr_data(lpr_data), .rx_vld(rx_vld),
    .rx_brk(rx_brk), .rx_char(rx_char), .rd_en(rd_en), .rd_data(rd_data),
    .rx_done(rx_done), .silo_alarm(silo_alarm), .rx_irq(rx_irq)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int mq [NL][$];
  bit men [NL];
  logic [15:0] exp_q [$];
  string tag_q [$];
  logic rd_d = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_d <= rd_en;

  always @(negedge clk)
    if (rd_d) begin
      if (exp_q.size() == 0) chk("R2 unexpected read", 1, 0);
      else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_line(int l, bit e);
    @(negedge clk);
    lpr_we = 1;
    lpr_data = 16'h0A58 | (16'(e) << 12) | 16'(l);
    men[l] = e;
    @(negedge clk);
    lpr_we = 0;
  endtask

  task automatic push(int l, logic [7:0] ch, bit brk);
    @(negedge clk);
    rx_vld[l] = 1; rx_brk[l] = brk; rx_char[l*CW +: CW] = ch;
    if (men[l] && mq[l].size() < QD) mq[l].push_back({brk, ch});
    @(negedge clk);
    rx_vld = '0; rx_brk = '0;
  endtask

  task automatic read(string tag);
    logic [15:0] w;
    int e;
    @(negedge clk);
    rd_en = 1;
    w = '0;
    if (scan_en)
      for (int l = 0; l < NL; l++)
        if (mq[l].size() > 0) begin
          e = mq[l].pop_front();
          w = 16'h8000 | 16'(l << 8) | (e[8] ? 16'h2000 : 16'(e[7:0]));
          break;
        end
    exp_q.push_back(w);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    for (int l = 0; l < NL; l++) begin mq[l].delete(); men[l] = 0; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < NL; l++) men[l] = 0;
    idle(3); rst_n = 1; idle(1);
    chk("R11 reset rd_data", rd_data, 0);
    chk("R11 reset rx_done", rx_done, 0);
    chk("R11 reset silo_alarm", silo_alarm, 0);
    chk("R7 reset rx_irq", rx_irq, 0);

    set_line(1, 1); set_line(3, 1); set_line(6, 1);
    scan_en = 1;
    push(5, 8'h55, 0);
    idle(1);
    chk("R9 disabled line rx_done", rx_done, 0);
    read("R9 disabled line read");

    scan_en = 0;
    push(3, 8'h33, 0); push(1, 8'h11, 0);
    idle(1);
    chk("R8 scan off rx_done", rx_done, 0);
    read("R8 scan off read");
    scan_en = 1; idle(1);
    chk("R4 done with data", rx_done, 1);
    read("R2 lowest line first");
    read("R1 second word");
    read("R2 empty read");
    idle(1);
    chk("R4 done after drain", rx_done, 0);

    push(6, 8'h7e, 1);
    read("R3 break word");

    rx_ie = 1;
    push(1, 8'h41, 0); idle(1);
    chk("R7 irq follows done", rx_irq, 1);
    alarm_ie = 1; idle(1);
    chk("R7 irq follows alarm", rx_irq, 0);
    alarm_ie = 0;
    read("R1 char word");
    idle(1);
    chk("R7 irq drops when empty", rx_irq, 0);

    for (int i = 0; i < 5; i++) push(3, 8'h60 + 8'(i), 0);
    for (int i = 0; i < 5; i++) read("R10 depth and drop");

    for (int l = 0; l < NL; l++) set_line(l, 1);
    for (int i = 0; i < 15; i++) push(i % NL, 8'h80 + 8'(i), 0);
    idle(2);
    chk("R5 below threshold", silo_alarm, 0);
    push(7, 8'h8f, 0); idle(2);
    chk("R5 alarm at threshold", silo_alarm, 1);
    alarm_ie = 1; idle(1);
    chk("R7 irq on alarm", rx_irq, 1);
    read("R5 read under alarm");
    idle(1);
    chk("R6 read clears alarm", silo_alarm, 0);
    chk("R7 irq cleared with alarm", rx_irq, 0);
    push(0, 8'h90, 0); idle(2);
    chk("R5 one-shot while disarmed", silo_alarm, 0);
    for (int i = 0; i < 16; i++) read("R2 drain");
    read("R6 empty read rearms");
    for (int i = 0; i < 16; i++) push(i % NL, 8'ha0 + 8'(i), 0);
    idle(2);
    chk("R6 alarm after rearm", silo_alarm, 1);
    scan_en = 0; idle(2);
    chk("R8 scan off clears alarm", silo_alarm, 0);
    chk("R8 scan off clears done", rx_done, 0);
    scan_en = 1; idle(2);
    chk("R5 stays disarmed", silo_alarm, 0);

    do_clear(); idle(1);
    chk("R11 clear empties", rx_done, 0);
    chk("R11 clear rd_data", rd_data, 0);
    push(2, 8'h22, 0); idle(1);
    chk("R11 enables cleared", rx_done, 0);
    read("R11 read after clear");
    for (int l = 0; l < NL; l++) set_line(l, 1);
    for (int i = 0; i < 16; i++) push(i % NL, 8'hc0 + 8'(i), 0);
    idle(2);
    chk("R6 clear rearms", silo_alarm, 1);

    idle(3);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule